// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Code Register Bank

This block holds the digital codes for a four-channel, 8-bit parallel digital-to-analog converter. Every channel owns two registers in series: a staging register that a host fills through a shared 8-bit bus, and an output register whose value drives the converter. A 2-bit channel select steers an active-low write strobe to one staging register, and a single active-low load strobe moves every staging value into its output register in the same cycle, so all four converters can change together.

The block is clocked. A level-sensitive latch is modelled as a register that follows its source in every cycle its enable is asserted and holds otherwise. Strobes, select and bus are sampled at the rising clock edge. When both strobes are low in the same cycle, the bus value passes through the selected staging register and into its output register at that one edge. Holding the load strobe low permanently turns the block into a single-buffered bank in which each write reaches the output directly.

Top module: `dacbank_top`

## Requirements
- R1: After reset, all four output codes are 8'h00, and a later load with no write in between also yields 8'h00 on every channel (staging registers preset to zero).
- R2: In a cycle with wr_n low, only the staging register of the selected channel takes bus_data at the clock edge; the other three staging registers keep their values.
- R3: In a cycle with wr_n high, no staging register changes, whatever bus_data and ch_sel carry.
- R4: In a cycle with ld_n low, all four output registers take the value their staging register holds after that edge, at the same edge.
- R5: In a cycle with ld_n high (and reset low), code_out does not change at the next edge.
- R6: In a cycle with wr_n and ld_n both low, the selected channel's output code equals that cycle's bus_data after the edge.
- R7: ch_sel value k (0 to 3, binary, 0 = first channel) selects channel k, and channel k's code appears on code_out bits [8k+7:8k].
- R8: With ld_n held low, each write reaches its channel's output one edge later; changing ch_sel while wr_n stays low moves the write to the new channel and the old channel keeps its last value.
- R9: Reset (rst high, synchronous, active high) clears all staging and output registers at the next edge regardless of wr_n, ld_n, ch_sel and bus_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Shared code bus |
| ch_sel | input | 2 | Channel select, binary |
| wr_n | input | 1 | Write strobe to the selected staging register, active low |
| ld_n | input | 1 | Load strobe for all output registers, active low |
| code_out | output | 32 | Four output codes, channel k at bits [8k+7:8k] |

## Verification
Every result of this block is due exactly one rising edge after the cycle whose strobes, select and bus cause it: a write, a load, a combined write-and-load and a reset all appear at the first edge, and nothing takes longer. The bench drives each stimulus half a period before an edge, lets the reference model of the eight registers advance at that edge, and compares all four output codes on the following falling edge. Staging contents that have no direct port are made visible by a later load, so every write and every ignored write is judged at code_out.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    // Default geometry of the bank
    localparam int DEF_NUM_CH = 4;
    localparam int DEF_CODE_W = 8;

    // Decoded strobe pair, active high inside the block
    typedef struct packed {
        logic wr;
        logic ld;
    } strobe_t;

    // Operation carried by one sampled cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LOAD  = 2'b10,
        OP_BOTH  = 2'b11
    } op_e;

    function automatic strobe_t decode_strobes(input logic wr_n, input logic ld_n);
        strobe_t s;
        s.wr = ~wr_n;
        s.ld = ~ld_n;
        return s;
    endfunction

    function automatic op_e strobe_op(input strobe_t s);
        return op_e'({s.ld, s.wr});
    endfunction

endpackage

// File: rtl/dacbank_sel_dec.sv
module dacbank_sel_dec
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_act,
    output logic [NUM_CH-1:0] wr_en
);
    // One enable per channel; at most one is set
    for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
        assign wr_en[k] = wr_act && (sel == SEL_W'(k));
    end
endmodule

// File: rtl/dacbank_stage_reg.sv
module dacbank_stage_reg
    import dacbank_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] nxt,
    output logic [CODE_W-1:0] q
);
    // Transparent-latch model: follows d while enabled, otherwise holds
    always_comb nxt = en ? d : q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/dacbank_out_reg.sv
module dacbank_out_reg
    import dacbank_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [CODE_W-1:0] src,
    output logic [CODE_W-1:0] q
);
    // src is the staging value as it will stand after this edge,
    // so a combined write and load passes the bus in one cycle
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= src;
    end
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    localparam int SEL_W = $clog2(NUM_CH),
    localparam int OUT_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] bus_data,
    input  logic [SEL_W-1:0]  ch_sel,
    input  logic              wr_n,
    input  logic              ld_n,
    output logic [OUT_W-1:0]  code_out
);
    strobe_t            strb;
    logic [NUM_CH-1:0]  wr_en;
    logic [OUT_W-1:0]   stage_flat;
    logic [OUT_W-1:0]   stage_nxt;

    assign strb = decode_strobes(wr_n, ld_n);

    dacbank_sel_dec #(.NUM_CH(NUM_CH)) dec_i (
        .sel    (ch_sel),
        .wr_act (strb.wr),
        .wr_en  (wr_en)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        dacbank_stage_reg #(.CODE_W(CODE_W)) stage_i (
            .clk (clk),
            .rst (rst),
            .en  (wr_en[k]),
            .d   (bus_data),
            .nxt (stage_nxt[k*CODE_W +: CODE_W]),
            .q   (stage_flat[k*CODE_W +: CODE_W])
        );

        dacbank_out_reg #(.CODE_W(CODE_W)) out_i (
            .clk (clk),
            .rst (rst),
            .ld  (strb.ld),
            .src (stage_nxt[k*CODE_W +: CODE_W]),
            .q   (code_out[k*CODE_W +: CODE_W])
        );
    end
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    localparam int SEL_W = $clog2(NUM_CH),
    localparam int OUT_W = NUM_CH * CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] bus_data,
    input logic [SEL_W-1:0]  ch_sel,
    input logic              wr_n,
    input logic              ld_n,
    input logic [OUT_W-1:0]  code_out,
    input logic [OUT_W-1:0]  stage_flat
);
    function automatic logic [CODE_W-1:0] pick(input logic [OUT_W-1:0] v,
                                               input logic [SEL_W-1:0] i);
        return v[i*CODE_W +: CODE_W];
    endfunction

    // R9 / R1: reset clears both register levels
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (code_out == '0) && (stage_flat == '0));

    // R5: outputs hold without a load
    a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> $stable(code_out));

    // R3: staging holds without a write
    a_r3_stage_hold: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> $stable(stage_flat));

    // R4: a load leaves outputs equal to staging
    a_r4_load_copies: assert property (@(posedge clk) disable iff (rst)
        !ld_n |=> code_out == stage_flat);

    // R6: combined strobes pass the bus to the selected output
    a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !ld_n) |=> pick(code_out, $past(ch_sel)) == $past(bus_data));

    // R2: a write lands in the selected staging register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        !wr_n |=> pick(stage_flat, $past(ch_sel)) == $past(bus_data));
endmodule

bind dacbank_top dacbank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_data   (bus_data),
    .ch_sel     (ch_sel),
    .wr_n       (wr_n),
    .ld_n       (ld_n),
    .code_out   (code_out),
    .stage_flat (stage_flat)
);

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;
    localparam int NCH = 4;
    localparam int CW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] bus_data = '0;
    logic [1:0]    ch_sel = '0;
    logic          wr_n = 1'b1;
    logic          ld_n = 1'b1;
    logic [NCH*CW-1:0] code_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [CW-1:0] m_stage [NCH];
    logic [CW-1:0] m_out   [NCH];

    always #10 clk = ~clk;   // 50 MHz

    dacbank_top dut_i (
        .clk(clk), .rst(rst), .bus_data(bus_data), .ch_sel(ch_sel),
        .wr_n(wr_n), .ld_n(ld_n), .code_out(code_out)
    );

    // Drive one cycle, advance the model at the edge, compare after it
    task automatic step(input logic r, input logic w_n, input logic l_n,
                        input logic [1:0] s, input logic [CW-1:0] d,
                        input string tag);
        @(negedge clk);
        rst = r; wr_n = w_n; ld_n = l_n; ch_sel = s; bus_data = d;
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < NCH; k++) begin
                m_stage[k] = '0;
                m_out[k]   = '0;
            end
        end else begin
            if (!w_n) m_stage[s] = d;
            if (!l_n) for (int k = 0; k < NCH; k++) m_out[k] = m_stage[k];
        end
        @(negedge clk);
        for (int k = 0; k < NCH; k++) begin
            n_vec++;
            if (code_out[k*CW +: CW] !== m_out[k]) begin
                n_fail++;
                $display("FAIL %s ch%0d: actual %h expected %h",
                         tag, k, code_out[k*CW +: CW], m_out[k]);
            end
        end
    endtask

    // R1 and R9: reset state, staging preset seen through a load
    task automatic t_reset;
        step(1, 1, 1, 2'd0, 8'h00, "R9");
        step(1, 1, 1, 2'd0, 8'h00, "R1");
        step(0, 1, 0, 2'd2, 8'h5A, "R1");
    endtask

    // R2, R3, R4, R7: stage four values, then load them together
    task automatic t_simultaneous;
        step(0, 0, 1, 2'd0, 8'h11, "R2");
        step(0, 0, 1, 2'd1, 8'h22, "R7");
        step(0, 0, 1, 2'd2, 8'h33, "R7");
        step(0, 0, 1, 2'd3, 8'h44, "R7");
        step(0, 1, 1, 2'd1, 8'hEE, "R3");
        step(0, 1, 0, 2'd3, 8'hDD, "R4");
        step(0, 0, 1, 2'd2, 8'h99, "R2");
        step(0, 1, 0, 2'd0, 8'h00, "R2");
    endtask

    // R5: outputs stay put while ld_n is high
    task automatic t_hold;
        step(0, 0, 1, 2'd3, 8'hA5, "R5");
        step(0, 0, 1, 2'd0, 8'h3C, "R5");
        step(0, 1, 1, 2'd1, 8'hFF, "R5");
        step(0, 1, 0, 2'd0, 8'h00, "R4");
    endtask

    // R6: both strobes low in one cycle
    task automatic t_both_low;
        step(0, 0, 1, 2'd1, 8'h77, "R6");
        step(0, 0, 0, 2'd2, 8'hC3, "R6");
        step(0, 0, 0, 2'd3, 8'h01, "R6");
    endtask

    // R8: load strobe held low, select moves during a long write
    task automatic t_ld_tied;
        step(0, 0, 0, 2'd0, 8'h80, "R8");
        step(0, 0, 0, 2'd0, 8'h81, "R8");
        step(0, 0, 0, 2'd1, 8'h82, "R8");
        step(0, 0, 0, 2'd3, 8'hFE, "R8");
        step(0, 1, 0, 2'd2, 8'h10, "R8");
    endtask

    // R9: reset wins over active strobes
    task automatic t_reset_override;
        step(1, 0, 0, 2'd1, 8'hBB, "R9");
        step(0, 1, 0, 2'd0, 8'h00, "R9");
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) begin
            m_stage[k] = '0;
            m_out[k]   = '0;
        end
        t_reset;
        t_simultaneous;
        t_hold;
        t_both_low;
        t_ld_tied;
        t_reset_override;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule